// File: doc/BRIEF.md
# Open-Drain Two-Wire Bit-Level Master

This block is a single-master engine for a two-wire serial bus of one clock line (SCL) and one data line (SDA). It never drives either line high. Each line has a pull enable: when the enable is set the pad pulls the line low, and when it is clear the line floats and an external resistor pulls it high. The real level of each line comes back through a sampled input. A host issues one command at a time: a start condition, a stop condition, a byte transmit, or a byte receive. A transmit selects per byte whether the most or the least significant bit goes out first. A receive carries a flag that marks the final byte of a read. The engine returns the slave's acknowledge as a not-acknowledged flag, the received byte, and a bus-error flag.

Every bus action is followed by a programmable quarter-bit wait, counted in system clock cycles. Whenever the engine lets SCL float, it waits until SCL reads high before it continues. This allows a slave to stretch the clock. If SCL stays low past a programmable limit, the engine ends the command with a bus error. The line inputs pass through a two-stage synchronizer before the engine uses them.

Top module: `twm_master`

## Requirements
- R1: After reset both pull enables are clear, `busy` is low and both lines read high. The engine only ever asserts a pull enable. It has no output that drives a line high.
- R2: A start command (`cmd_op` = 0) releases SDA, releases SCL, pulls SDA low while SCL is high, and then pulls SCL low. It ends with both lines low.
- R3: A stop command (`cmd_op` = 1), issued while SCL is low, pulls SDA low, releases SCL, and then releases SDA while SCL is high. It ends with both lines high.
- R4: A transmit command (`cmd_op` = 2) puts `cmd_data` on SDA one bit per SCL pulse. The most significant bit goes first when `cmd_msb_first` = 1, and the least significant bit goes first when it is 0.
- R5: After eight data bits of a transmit, the engine releases SDA, clocks a ninth pulse and samples SDA while SCL is high. `rsp_nack` is 0 if the slave held SDA low and 1 otherwise.
- R6: A receive command (`cmd_op` = 3) samples SDA during eight SCL-high periods. The first bit sampled is placed in bit 0 of `rsp_data` and the last in bit 7.
- R7: After eight received bits, the engine pulls SDA low through the ninth pulse when `cmd_last` = 0. It leaves SDA released during that pulse when `cmd_last` = 1.
- R8: During transmit and receive, SDA changes only while SCL is low. Start, transmit and receive all finish with SCL held low.
- R9: Every action is followed by a quarter-bit wait of `QTR_CYC` cycles. Each SCL high phase therefore lasts at least `QTR_CYC` cycles, and each low phase lasts at least 2×`QTR_CYC` cycles.
- R10: After releasing SCL, the engine waits until the synchronized SCL input reads high before starting the next quarter-bit wait. A slave that holds SCL low for less than the limit changes only the timing and causes no error.
- R11: If SCL reads low for `SCL_TO_CYC` cycles after a release, the command ends: `bus_err` rises together with `done`. The next accepted command clears `bus_err`.
- R12: A command is accepted when `cmd_valid` is high while `busy` is low. `busy` is high from the cycle after acceptance until the cycle in which `done` pulses. A `cmd_valid` that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request, accepted when the engine is idle |
| cmd_op | input | 2 | Command: 0 start, 1 stop, 2 transmit, 3 receive |
| cmd_msb_first | input | 1 | Transmit order: 1 = most significant bit first |
| cmd_last | input | 1 | Receive: 1 = final byte, answer with no acknowledge |
| cmd_data | input | BYTE_W | Byte to transmit |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle pulse when a command ends |
| rsp_nack | output | 1 | Slave did not acknowledge the last transmit |
| rsp_data | output | BYTE_W | Byte assembled by the last receive |
| bus_err | output | 1 | SCL stayed low past the limit |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| scl_pull | output | 1 | Pull SCL low when 1 |
| sda_pull | output | 1 | Pull SDA low when 1 |

## Verification
The bench transmits every byte value in both bit orders and receives every byte value, with the final-byte flag alternating. A mistake in the bit order, an off-by-one in the bit count, or an assembly in the wrong direction therefore corrupts many values. A monitor counts start and stop conditions, and flags any SDA edge that occurs while SCL is high inside a byte. An engine that moved SDA before pulling SCL low would create false starts or stops. The bench also drops the acknowledge to prove that `rsp_nack` follows the line. It stretches SCL below the limit and holds it past the limit, to tell a missing wait from a missing timeout. Finally, it pulses a stray command during a transfer: an engine that accepted it would emit an extra stop and corrupt the byte.

// File: rtl/twm_pkg.sv
`timescale 1ns/1ps
package twm_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_SEND  = 2'd2,
    OP_RECV  = 2'd3
  } twm_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACT,
    ST_SCLW,
    ST_QTR
  } twm_st_e;

  typedef enum logic [2:0] {
    AC_SDA_REL,
    AC_SDA_PULL,
    AC_SDA_TX,
    AC_SCL_REL,
    AC_SCL_PULL
  } twm_act_e;

  typedef struct packed {
    twm_act_e act;
    logic     sample;
    logic     final_step;
    logic     adv_bit;
  } twm_step_t;
endpackage

// File: rtl/twm_sync.sv
`timescale 1ns/1ps
module twm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff_q <= '1;
    else        ff_q <= {ff_q[STAGES-2:0], d};
  end

  assign q = ff_q[STAGES-1];
endmodule

// File: rtl/twm_cnt.sv
`timescale 1ns/1ps
module twm_cnt #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  output logic hit
);
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] C_ONE = W'(1);
  localparam logic [W-1:0] C_END = W'(LIMIT - 1);

  logic [W-1:0] c_q, c_d;

  assign hit = en && (c_q == C_END);

  always_comb begin
    c_d = c_q;
    if (clr || hit) c_d = '0;
    else if (en)    c_d = c_q + C_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) c_q <= '0;
    else        c_q <= c_d;
  end
endmodule

// File: rtl/twm_shift.sv
`timescale 1ns/1ps
module twm_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         msb_first,
  input  logic         tx_adv,
  input  logic         rx_adv,
  input  logic         rx_bit,
  output logic         tx_bit,
  output logic [W-1:0] data
);
  logic [W-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (load)
      sr_d = load_data;
    else if (rx_adv)
      sr_d = {rx_bit, sr_q[W-1:1]};
    else if (tx_adv)
      sr_d = msb_first ? {sr_q[W-2:0], 1'b0} : {1'b0, sr_q[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign tx_bit = msb_first ? sr_q[W-1] : sr_q[0];
  assign data   = sr_q;
endmodule

// File: rtl/twm_master.sv
`timescale 1ns/1ps
module twm_master
  import twm_pkg::*;
#(
  parameter int QTR_CYC    = 15,
  parameter int SCL_TO_CYC = 256,
  parameter int BYTE_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic              cmd_msb_first,
  input  logic              cmd_last,
  input  logic [BYTE_W-1:0] cmd_data,
  output logic              busy,
  output logic              done,
  output logic              rsp_nack,
  output logic [BYTE_W-1:0] rsp_data,
  output logic              bus_err,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_pull,
  output logic              sda_pull
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] BIT_END = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] BIT_ONE = CNT_W'(1);

  twm_st_e          st_q, st_d;
  twm_op_e          op_q, op_d;
  logic             msb_q, msb_d, last_q, last_d;
  logic [CNT_W-1:0] bit_q, bit_d;
  logic [1:0]       ph_q, ph_d;
  logic             scl_q, scl_d, sda_q, sda_d;
  logic             nack_q, nack_d, err_q, err_d;
  logic             busy_q, busy_d, done_q, done_d;
  twm_step_t        stp;
  logic             scl_s, sda_s, q_hit, to_hit;
  logic             sh_load, tx_adv, rx_adv, tx_bit;
  logic             in_bits;

  // line synchronizers
  twm_sync #(.STAGES(2)) u_sync_scl (.clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s));
  twm_sync #(.STAGES(2)) u_sync_sda (.clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s));

  // quarter-bit wait and SCL release timeout
  twm_cnt #(.LIMIT(QTR_CYC)) u_qtr (
    .clk(clk), .rst_n(rst_n), .en(st_q == ST_QTR), .clr(st_q != ST_QTR), .hit(q_hit));
  twm_cnt #(.LIMIT(SCL_TO_CYC)) u_tout (
    .clk(clk), .rst_n(rst_n), .en(st_q == ST_SCLW), .clr(st_q != ST_SCLW), .hit(to_hit));

  twm_shift #(.W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .load_data(cmd_data),
    .msb_first(msb_q), .tx_adv(tx_adv), .rx_adv(rx_adv), .rx_bit(sda_s),
    .tx_bit(tx_bit), .data(rsp_data));

  assign in_bits = (bit_q < BIT_END);

  // step decode: which action the current (op, bit, phase) performs
  always_comb begin
    stp.act        = AC_SDA_REL;
    stp.sample     = 1'b0;
    stp.final_step = 1'b0;
    stp.adv_bit    = 1'b0;
    case (op_q)
      OP_START: begin
        case (ph_q)
          2'd0: stp.act = AC_SDA_REL;
          2'd1: stp.act = AC_SCL_REL;
          2'd2: stp.act = AC_SDA_PULL;
          default: begin stp.act = AC_SCL_PULL; stp.final_step = 1'b1; end
        endcase
      end
      OP_STOP: begin
        case (ph_q)
          2'd0: stp.act = AC_SDA_PULL;
          2'd1: stp.act = AC_SCL_REL;
          default: begin stp.act = AC_SDA_REL; stp.final_step = 1'b1; end
        endcase
      end
      default: begin
        if (in_bits) begin
          case (ph_q)
            2'd0: stp.act = (op_q == OP_SEND) ? AC_SDA_TX : AC_SDA_REL;
            2'd1: begin stp.act = AC_SCL_REL; stp.sample = (op_q == OP_RECV); end
            default: begin stp.act = AC_SCL_PULL; stp.adv_bit = 1'b1; end
          endcase
        end else begin
          case (ph_q)
            2'd0: stp.act = (op_q == OP_SEND || last_q) ? AC_SDA_REL : AC_SDA_PULL;
            2'd1: begin stp.act = AC_SCL_REL; stp.sample = (op_q == OP_SEND); end
            2'd2: begin stp.act = AC_SCL_PULL; stp.final_step = (op_q == OP_SEND); end
            default: begin stp.act = AC_SDA_REL; stp.final_step = 1'b1; end
          endcase
        end
      end
    endcase
  end

  // next state
  always_comb begin
    st_d    = st_q;
    op_d    = op_q;
    msb_d   = msb_q;
    last_d  = last_q;
    bit_d   = bit_q;
    ph_d    = ph_q;
    scl_d   = scl_q;
    sda_d   = sda_q;
    nack_d  = nack_q;
    err_d   = err_q;
    busy_d  = busy_q;
    done_d  = 1'b0;
    sh_load = 1'b0;
    tx_adv  = 1'b0;
    rx_adv  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          op_d    = twm_op_e'(cmd_op);
          msb_d   = cmd_msb_first;
          last_d  = cmd_last;
          bit_d   = '0;
          ph_d    = 2'd0;
          busy_d  = 1'b1;
          err_d   = 1'b0;
          nack_d  = 1'b0;
          sh_load = 1'b1;
          st_d    = ST_ACT;
        end
      end
      ST_ACT: begin
        case (stp.act)
          AC_SDA_REL:  sda_d = 1'b0;
          AC_SDA_PULL: sda_d = 1'b1;
          AC_SDA_TX:   sda_d = ~tx_bit;
          AC_SCL_REL:  scl_d = 1'b0;
          AC_SCL_PULL: scl_d = 1'b1;
          default:     sda_d = sda_q;
        endcase
        st_d = (stp.act == AC_SCL_REL) ? ST_SCLW : ST_QTR;
      end
      ST_SCLW: begin
        if (scl_s) begin
          st_d = ST_QTR;
        end else if (to_hit) begin
          err_d  = 1'b1;
          busy_d = 1'b0;
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end
      end
      default: begin
        if (q_hit) begin
          if (stp.sample) begin
            if (op_q == OP_SEND) nack_d = sda_s;
            else                 rx_adv = 1'b1;
          end
          if (stp.adv_bit) begin
            tx_adv = (op_q == OP_SEND);
            bit_d  = bit_q + BIT_ONE;
            ph_d   = 2'd0;
          end else begin
            ph_d = ph_q + 2'd1;
          end
          if (stp.final_step) begin
            busy_d = 1'b0;
            done_d = 1'b1;
            st_d   = ST_IDLE;
          end else begin
            st_d = ST_ACT;
          end
        end
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_START;
      msb_q  <= 1'b0;
      last_q <= 1'b0;
      bit_q  <= '0;
      ph_q   <= 2'd0;
      scl_q  <= 1'b0;
      sda_q  <= 1'b0;
      nack_q <= 1'b0;
      err_q  <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      op_q   <= op_d;
      msb_q  <= msb_d;
      last_q <= last_d;
      bit_q  <= bit_d;
      ph_q   <= ph_d;
      scl_q  <= scl_d;
      sda_q  <= sda_d;
      nack_q <= nack_d;
      err_q  <= err_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign scl_pull = scl_q;
  assign sda_pull = sda_q;
  assign busy     = busy_q;
  assign done     = done_q;
  assign rsp_nack = nack_q;
  assign bus_err  = err_q;
endmodule

// File: rtl/twm_master_chk.sv
`timescale 1ns/1ps
module twm_master_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic busy,
  input logic done,
  input logic bus_err,
  input logic scl_pull,
  input logic sda_pull
);
  // R12: an idle request is taken on the next edge
  a_r12_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy) |=> busy);

  // R12: done only marks the end of a busy period
  a_r12_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R11: a timeout error always ends the command
  a_r11_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_err) |-> done);

  // R1: the two lines never switch in the same cycle
  a_r1_one_line_per_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(scl_pull) |-> $stable(sda_pull));

  // R8: line drive never moves while no command runs
  a_r8_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(busy) |-> ($stable(scl_pull) && $stable(sda_pull)));
endmodule

bind twm_master twm_master_chk i_twm_master_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .busy(busy), .done(done),
  .bus_err(bus_err), .scl_pull(scl_pull), .sda_pull(sda_pull));

// File: tb/test_twm_master.sv
`timescale 1ns/1ps
module test_twm_master;
  localparam int QTR = 2;
  localparam int TOC = 30;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic       cmd_msb_first = 1'b0;
  logic       cmd_last = 1'b0;
  logic [7:0] cmd_data = 8'd0;
  logic       busy, done, rsp_nack, bus_err, scl_pull, sda_pull;
  logic [7:0] rsp_data;
  logic       tb_scl_hold = 1'b0;
  logic       tb_sda_pull = 1'b0;
  wire        scl_line = ~(scl_pull | tb_scl_hold);
  wire        sda_line = ~(sda_pull | tb_sda_pull);

  int checks = 0, fails = 0;
  int start_cnt = 0, stop_cnt = 0, viol = 0;
  int min_hi = 1000000, min_lo = 1000000, run_len = 0;
  bit mon_on = 0, in_byte = 0, have_edge = 0, prev_scl = 1, finished = 0;
  logic [7:0] got_byte;
  logic       mack, busy_at_accept;

  always #2.5 clk = ~clk;

  twm_master #(.QTR_CYC(QTR), .SCL_TO_CYC(TOC), .BYTE_W(8)) i_twm_master (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_msb_first(cmd_msb_first), .cmd_last(cmd_last), .cmd_data(cmd_data),
    .busy(busy), .done(done), .rsp_nack(rsp_nack), .rsp_data(rsp_data),
    .bus_err(bus_err), .scl_in(scl_line), .sda_in(sda_line),
    .scl_pull(scl_pull), .sda_pull(sda_pull));

  // bus monitors
  always @(negedge sda_line) if (mon_on && scl_line) start_cnt++;
  always @(posedge sda_line) if (mon_on && scl_line) stop_cnt++;
  always @(sda_line) if (mon_on && in_byte && scl_line) viol++;

  always @(negedge clk) begin
    if (mon_on) begin
      if (scl_line == prev_scl) run_len++;
      else begin
        if (have_edge) begin
          if (prev_scl) begin if (run_len < min_hi) min_hi = run_len; end
          else begin if (run_len < min_lo) min_lo = run_len; end
        end
        have_edge = 1;
        run_len = 1;
      end
      prev_scl = scl_line;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] v);
    for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
  endfunction

  task automatic do_cmd(input logic [1:0] op, input logic msb, input logic last,
                        input logic [7:0] d);
    @(negedge clk);
    cmd_op = op; cmd_msb_first = msb; cmd_last = last; cmd_data = d;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    busy_at_accept = busy;
    while (!done) @(negedge clk);
  endtask

  task automatic slave_rx(input logic ack_pull, input bit stretch);
    got_byte = 8'd0;
    for (int i = 0; i < 8; i++) begin
      @(posedge scl_line);
      got_byte = {got_byte[6:0], sda_line};
      @(negedge scl_line);
      if (stretch && i == 3) begin
        tb_scl_hold = 1'b1;
        repeat (12) @(posedge clk);
        tb_scl_hold = 1'b0;
      end
    end
    tb_sda_pull = ack_pull;
    @(posedge scl_line);
    @(negedge scl_line);
    tb_sda_pull = 1'b0;
  endtask

  task automatic slave_tx(input logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      @(posedge scl_line);
      @(negedge scl_line);
      if (i < 7) tb_sda_pull = ~v[i+1];
      else       tb_sda_pull = 1'b0;
    end
    @(posedge scl_line);
    mack = ~sda_line;
    @(negedge scl_line);
  endtask

  task automatic send_byte(input logic [7:0] v, input logic msb, input logic ack, input bit stretch);
    fork
      do_cmd(2'd2, msb, 1'b0, v);
      slave_rx(ack, stretch);
    join
  endtask

  task automatic recv_byte(input logic [7:0] v, input logic last);
    tb_sda_pull = ~v[0];
    fork
      do_cmd(2'd3, 1'b0, last, 8'd0);
      slave_tx(v);
    join
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int s0;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    mon_on = 1;
    // R1 reset state
    chk(scl_pull == 0 && sda_pull == 0, "R1 pulls after reset", {scl_pull, sda_pull}, 0);
    chk(busy == 0, "R1 busy after reset", busy, 0);
    chk(scl_line && sda_line, "R1 lines high after reset", {scl_line, sda_line}, 3);

    // R2 start
    s0 = start_cnt;
    do_cmd(2'd0, 1'b0, 1'b0, 8'd0);
    chk(start_cnt == s0 + 1, "R2 start condition count", start_cnt - s0, 1);
    chk(!scl_line && !sda_line, "R2 lines low after start", {scl_line, sda_line}, 0);
    chk(busy_at_accept == 1, "R12 busy after accept", busy_at_accept, 1);

    // R4/R5/R8 transmit sweep, both orders
    in_byte = 1;
    for (int v = 0; v < 256; v++) begin
      for (int o = 0; o < 2; o++) begin
        logic [7:0] exp;
        send_byte(v[7:0], o[0], 1'b1, 0);
        exp = o[0] ? v[7:0] : rev8(v[7:0]);
        chk(got_byte == exp, "R4 transmit bit order", got_byte, exp);
        chk(rsp_nack == 0, "R5 ack seen", rsp_nack, 0);
        chk(!scl_line, "R8 SCL low after transmit", scl_line, 0);
      end
    end

    // R5 missing acknowledge
    send_byte(8'h5A, 1'b1, 1'b0, 0);
    chk(rsp_nack == 1, "R5 nack flagged", rsp_nack, 1);
    chk(got_byte == 8'h5A, "R4 byte with nack", got_byte, 8'h5A);

    // R10 clock stretch below the limit
    send_byte(8'hC3, 1'b0, 1'b1, 1);
    chk(got_byte == rev8(8'hC3), "R10 byte with stretch", got_byte, rev8(8'hC3));
    chk(bus_err == 0, "R10 no error on stretch", bus_err, 0);

    // R12 request while busy is ignored
    s0 = stop_cnt;
    fork
      send_byte(8'h3C, 1'b1, 1'b1, 0);
      begin
        repeat (20) @(negedge clk);
        cmd_op = 2'd1; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
      end
    join
    repeat (QTR * 6) @(negedge clk);
    chk(stop_cnt == s0, "R12 stray stop ignored", stop_cnt - s0, 0);
    chk(got_byte == 8'h3C, "R12 byte intact", got_byte, 8'h3C);
    chk(busy == 0 && !scl_line, "R12 engine idle after byte", {busy, scl_line}, 0);

    // R6/R7 receive sweep
    for (int v = 0; v < 256; v++) begin
      recv_byte(v[7:0], v[0]);
      chk(rsp_data == v[7:0], "R6 receive assembly", rsp_data, v);
      chk(mack == !v[0], "R7 master ack", mack, !v[0]);
      chk(!scl_line, "R8 SCL low after receive", scl_line, 0);
    end
    in_byte = 0;

    // R3 stop
    s0 = stop_cnt;
    do_cmd(2'd1, 1'b0, 1'b0, 8'd0);
    chk(stop_cnt == s0 + 1, "R3 stop condition count", stop_cnt - s0, 1);
    chk(scl_line && sda_line, "R3 lines high after stop", {scl_line, sda_line}, 3);

    // R11 timeout
    tb_scl_hold = 1'b1;
    do_cmd(2'd0, 1'b0, 1'b0, 8'd0);
    chk(bus_err == 1, "R11 timeout error", bus_err, 1);
    chk(busy == 0, "R11 command ended", busy, 0);
    tb_scl_hold = 1'b0;
    repeat (4) @(negedge clk);
    do_cmd(2'd0, 1'b0, 1'b0, 8'd0);
    chk(bus_err == 0, "R11 error cleared", bus_err, 0);
    do_cmd(2'd1, 1'b0, 1'b0, 8'd0);

    // R8/R9 bus timing summary
    chk(viol == 0, "R8 SDA moved with SCL high", viol, 0);
    chk(min_hi >= QTR, "R9 SCL high time", min_hi, QTR);
    chk(min_lo >= 2 * QTR, "R9 SCL low time", min_lo, 2 * QTR);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule